// File: doc/BRIEF.md
# Programmable Supply Voltage Detector

This block watches a digitized supply-voltage reading and tells the rest of the chip whether the supply has sagged under a software-selected limit. Each reading is an unsigned code in 10 mV units, qualified by a valid strobe. A 3-bit level select picks one of eight limits, evenly spaced by 100 mV from 2.20 V up to 2.90 V. A 100 mV hysteresis band keeps a noisy supply from making the flag chatter.

The block drives a registered below-limit flag and two one-cycle event pulses for an external interrupt controller. One pulse marks the supply dropping through the limit and the other marks it recovering. Each pulse has its own enable. When the detector is switched off, the flag reads 0. After a standby indication the flag also reads 0, and it stays there until software clears the enable and sets it again.

Top module: `svd_top`

## Requirements
- R1: The level select value s (0 to 7) selects a falling trip code of 220 + 10*s, which is 2.20 V to 2.90 V in 10 mV units. The rising trip code is that value plus 10 (100 mV).
- R2: A valid sample taken while the detector is active, with code below the falling trip code, sets `below_o` to 1 at the next clock edge.
- R3: A valid active sample with code at or above the rising trip code clears `below_o` at the next edge. A code inside the band (at least the falling code and below the rising code) leaves `below_o` unchanged.
- R4: While `det_en_i` is 0, `below_o` is 0 from the next edge on, and neither event pulse fires.
- R5: A cycle with `standby_i` high forces `below_o` to 0. The flag then stays 0, whatever the samples are, until `det_en_i` has been seen low and is set high again.
- R6: A cycle with `sample_vld_i` low never changes `below_o` while the detector is active.
- R7: `fall_ev_o` pulses for exactly one cycle, in the same cycle that `below_o` first reads 1 after a 0-to-1 change, if `fall_ev_en_i` was 1 with the triggering sample. `rise_ev_o` does the same for a 1-to-0 change with `rise_ev_en_i`. Forced clears caused by disable or standby raise no event.
- R8: A change of level select while active takes effect at the next valid sample. If the flag value does not change, no event fires.
- R9: After reset, `below_o`, `rise_ev_o` and `fall_ev_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_code_i | input | CODE_W | Supply reading, 10 mV per LSB |
| sample_vld_i | input | 1 | Sample qualifier |
| det_en_i | input | 1 | Detector enable |
| level_sel_i | input | SEL_W | Trip level select |
| standby_i | input | 1 | Standby entry indication |
| rise_ev_en_i | input | 1 | Enable pulse on supply recovery |
| fall_ev_en_i | input | 1 | Enable pulse on supply drop |
| below_o | output | 1 | Supply below trip level |
| rise_ev_o | output | 1 | One-cycle recovery event |
| fall_ev_o | output | 1 | One-cycle drop event |

## Verification
An off-by-one in the trip table or the band compare shows up as a flag edge one code early or late, on the first sweep sample that crosses the limit. The bench therefore steps every code across every level in both directions and compares each cycle. A stale standby lock or a lock that clears too early shows up as a flag that stays at 0, or wakes too soon, on the first low sample after standby. An event register that is not cleared shows up as a pulse two cycles wide, which the very next cycle reveals.

// File: rtl/svd_pkg.sv
package svd_pkg;
   // Trip code for a level select value: base plus a fixed step per level.
   function automatic int unsigned trip_code(input int unsigned base,
                                             input int unsigned step,
                                             input int unsigned sel);
      return base + step * sel;
   endfunction
endpackage

// File: rtl/svd_thr_table.sv
module svd_thr_table #(
   parameter int unsigned CODE_W   = 10,
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned BASE     = 220,
   parameter int unsigned STEP     = 10,
   parameter int unsigned HYST     = 10,
   parameter bit          USE_TABLE = 1'b1
) (
   input  logic [SEL_W-1:0]  sel_i,
   output logic [CODE_W-1:0] fall_thr_o,
   output logic [CODE_W-1:0] rise_thr_o
);
   localparam int unsigned NLEV = 1 << SEL_W;
   localparam int unsigned TOP  = svd_pkg::trip_code(BASE, STEP, NLEV - 1) + HYST;

   if (TOP >= (1 << CODE_W)) begin : g_width_bad
      $error("svd_thr_table: CODE_W too narrow for highest trip code");
   end

   if (USE_TABLE) begin : g_table
      logic [CODE_W-1:0] fall_tbl [NLEV];
      for (genvar i = 0; i < NLEV; i++) begin : g_lev
         assign fall_tbl[i] = CODE_W'(svd_pkg::trip_code(BASE, STEP, i));
      end
      assign fall_thr_o = fall_tbl[sel_i];
   end else begin : g_math
      assign fall_thr_o = CODE_W'(BASE) + CODE_W'(STEP) * CODE_W'(sel_i);
   end

   assign rise_thr_o = fall_thr_o + CODE_W'(HYST);
endmodule

// File: rtl/svd_hyst.sv
module svd_hyst #(
   parameter int unsigned CODE_W = 10
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [CODE_W-1:0] code_i,
   input  logic              vld_i,
   input  logic              en_i,
   input  logic              standby_i,
   input  logic [CODE_W-1:0] fall_thr_i,
   input  logic [CODE_W-1:0] rise_thr_i,
   output logic              flag_o,
   output logic              set_o,
   output logic              clr_o
);
   logic lock_q, flag_q, active;
   logic go_low, go_high;

   assign active  = en_i && !standby_i && !lock_q && vld_i;
   assign go_low  = code_i < fall_thr_i;
   assign go_high = code_i >= rise_thr_i;
   assign set_o   = active && go_low && !flag_q;
   assign clr_o   = active && go_high && flag_q;
   assign flag_o  = flag_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lock_q <= 1'b0;
      end else if (standby_i) begin
         lock_q <= 1'b1;
      end else if (!en_i) begin
         lock_q <= 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_q <= 1'b0;
      end else if (!en_i || standby_i || lock_q) begin
         flag_q <= 1'b0;
      end else if (set_o) begin
         flag_q <= 1'b1;
      end else if (clr_o) begin
         flag_q <= 1'b0;
      end
   end

   // R3
   band_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active && code_i >= fall_thr_i && code_i < rise_thr_i) |=> (flag_q == $past(flag_q)));
   // R6
   novalid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!vld_i && en_i && !standby_i && !lock_q) |=> $stable(flag_q));
   // R5
   standby_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      standby_i |=> !flag_q);
endmodule

// File: rtl/svd_evt.sv
module svd_evt (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   input  logic rise_en_i,
   input  logic fall_en_i,
   input  logic flag_i,
   output logic rise_ev_o,
   output logic fall_ev_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rise_ev_o <= 1'b0;
         fall_ev_o <= 1'b0;
      end else begin
         rise_ev_o <= clr_i && rise_en_i;
         fall_ev_o <= set_i && fall_en_i;
      end
   end

   // R7
   fall_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_ev_o |=> !fall_ev_o);
   // R7
   rise_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_ev_o |=> !rise_ev_o);
   // R7
   fall_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_ev_o |-> (flag_i && !$past(flag_i)));
   // R7
   rise_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_ev_o |-> (!flag_i && $past(flag_i)));
endmodule

// File: rtl/svd_top.sv
module svd_top #(
   parameter int unsigned CODE_W    = 10,
   parameter int unsigned SEL_W     = 3,
   parameter int unsigned BASE      = 220,
   parameter int unsigned STEP      = 10,
   parameter int unsigned HYST      = 10,
   parameter bit          USE_TABLE = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [CODE_W-1:0] sample_code_i,
   input  logic              sample_vld_i,
   input  logic              det_en_i,
   input  logic [SEL_W-1:0]  level_sel_i,
   input  logic              standby_i,
   input  logic              rise_ev_en_i,
   input  logic              fall_ev_en_i,
   output logic              below_o,
   output logic              rise_ev_o,
   output logic              fall_ev_o
);
   if (HYST == 0) begin : g_hyst_bad
      $error("svd_top: HYST must be non-zero");
   end

   logic [CODE_W-1:0] fall_thr, rise_thr;
   logic              set_s, clr_s;

   svd_thr_table #(
      .CODE_W(CODE_W), .SEL_W(SEL_W), .BASE(BASE), .STEP(STEP),
      .HYST(HYST), .USE_TABLE(USE_TABLE)
   ) u_thr (
      .sel_i(level_sel_i), .fall_thr_o(fall_thr), .rise_thr_o(rise_thr)
   );

   svd_hyst #(.CODE_W(CODE_W)) u_hyst (
      .clk_i(clk_i), .rst_ni(rst_ni), .code_i(sample_code_i),
      .vld_i(sample_vld_i), .en_i(det_en_i), .standby_i(standby_i),
      .fall_thr_i(fall_thr), .rise_thr_i(rise_thr),
      .flag_o(below_o), .set_o(set_s), .clr_o(clr_s)
   );

   svd_evt u_evt (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_s), .clr_i(clr_s),
      .rise_en_i(rise_ev_en_i), .fall_en_i(fall_ev_en_i), .flag_i(below_o),
      .rise_ev_o(rise_ev_o), .fall_ev_o(fall_ev_o)
   );

   // R4
   disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !det_en_i |=> (!below_o && !rise_ev_o && !fall_ev_o));
   // R7
   no_dual_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rise_ev_o && fall_ev_o));
endmodule

// File: tb/tb_svd_top.sv
module tb_svd_top;
   localparam int CODE_W = 10;
   localparam int SEL_W  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [CODE_W-1:0] code = '0;
   logic vld = 1'b0, en = 1'b0, stby = 1'b0, ren = 1'b0, fen = 1'b0;
   logic [SEL_W-1:0] sel = '0;
   logic below, rev, fev;

   int checks = 0, errors = 0;
   logic e_flag = 1'b0, e_lock = 1'b0, e_rev = 1'b0, e_fev = 1'b0;

   always #4 clk = ~clk;

   svd_top dut (
      .clk_i(clk), .rst_ni(rst_n), .sample_code_i(code), .sample_vld_i(vld),
      .det_en_i(en), .level_sel_i(sel), .standby_i(stby),
      .rise_ev_en_i(ren), .fall_ev_en_i(fen),
      .below_o(below), .rise_ev_o(rev), .fall_ev_o(fev)
   );

   task automatic check(input string tag);
      checks++;
      if (below !== e_flag || rev !== e_rev || fev !== e_fev) begin
         errors++;
         $display("FAIL %s flag/rise/fall actual %b%b%b expected %b%b%b code=%0d sel=%0d",
                  tag, below, rev, fev, e_flag, e_rev, e_fev, code, sel);
      end
   endtask

   // One clock: model follows the requirements using inputs held over the edge.
   task automatic step(input string tag);
      int unsigned fthr, rthr;
      logic act, nf;
      fthr = 220 + 10 * int'(sel);          // R1
      rthr = fthr + 10;
      act  = en && !stby && !e_lock && vld;
      nf   = e_flag;
      if (act && code < fthr)  nf = 1'b1;   // R2
      if (act && code >= rthr) nf = 1'b0;   // R3
      e_fev = act && nf && !e_flag && fen;  // R7
      e_rev = act && !nf && e_flag && ren;
      if (!en || stby || e_lock) nf = 1'b0; // R4 R5
      e_flag = nf;
      if (stby) e_lock = 1'b1; else if (!en) e_lock = 1'b0;
      @(posedge clk);
      #2;
      check(tag);
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check("R9");
      rst_n = 1'b1;
      step("R9");
      check("R9");

      // R1 R2 R3 R7: full sweep down and back up for every level
      en = 1'b1; vld = 1'b1;
      for (int s = 0; s < 8; s++) begin
         sel = SEL_W'(s);
         ren = (s != 3);
         fen = (s != 5);
         for (int c = 330; c >= 190; c--) begin code = CODE_W'(c); step("R1"); end
         for (int c = 190; c <= 330; c++) begin code = CODE_W'(c); step("R3"); end
      end

      // R6: no update without valid
      sel = 3'd2; ren = 1'b1; fen = 1'b1;
      code = 300; step("R6");
      vld = 1'b0; code = 100;
      for (int i = 0; i < 4; i++) step("R6");
      vld = 1'b1; step("R6");
      vld = 1'b0; code = 300; step("R6");
      vld = 1'b1; step("R6");

      // R8: level change inside band with no event, then crossing
      sel = 3'd0; code = 225; step("R8");       // 225 < 220? no -> stays 0
      sel = 3'd7; step("R8");                   // 225 < 290 -> sets, event
      sel = 3'd6; code = 285; step("R8");       // band of 280..290 -> hold 1
      sel = 3'd0; step("R8");                   // 285 >= 230 -> clears
      sel = 3'd0; code = 229; step("R8");       // inside band, hold 0

      // R4: disable forces flag low, no events, even with low codes
      code = 100; step("R4");
      en = 1'b0;
      for (int i = 0; i < 3; i++) step("R4");
      code = 400; step("R4");
      en = 1'b1; code = 100; step("R4");

      // R5: standby clears and locks until enable toggles
      stby = 1'b1; step("R5");
      stby = 1'b0;
      for (int i = 0; i < 4; i++) step("R5");
      en = 1'b0; step("R5");
      en = 1'b1; step("R5");
      step("R5");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule